// File: doc/BRIEF.md
# H-Bridge Gate Command Sequencer

This block takes the control requests for a full bridge (direction, the external on/off drive, the external decay selection, and the fast/slow state of the internal current chopper) and produces the four gate commands of the bridge. Each of the two legs has a high-side (source) switch and a low-side (sink) switch. While the bridge is driving, the source of one leg and the sink of the other leg conduct. While it is decaying, the block routes the recirculating current either through the opposite diagonal (fast decay) or through both sinks (slow decay, which is also the braking configuration).

Protection is built into the same path. When the winding current reaches zero during decay, a zero-current input turns every switch off. This shutoff is latched until the next drive period, so the current cannot reverse. Over-temperature, low regulator voltage, low logic supply and sleep each force all four commands off. A low charge-pump voltage removes only the two source commands. Every leg has a dead-time sequencer. A switch is turned on only after its leg has had both switches off for a set number of clock cycles, and a change from source to sink always goes through the off state.

The clock is the oscillator that times the block. `DEAD_CYC` is the number of clock cycles of crossover delay, chosen to suit the oscillator frequency.

Top module: `hbg_top`

## Requirements
- R1: With the drive active (`drive_en_i`=1, `chop_off_i`=0), the settled outputs depend on `dir_i`. `dir_i`=1 turns on source A and sink B. `dir_i`=0 turns on sink A and source B. The other two switches stay off.
- R2: With `drive_en_i`=0 and `ext_slow_i`=0 (fast decay), the settled outputs turn on the opposite diagonal. For `dir_i`=1 that is sink A and source B; for `dir_i`=0 it is source A and sink B.
- R3: With `drive_en_i`=0 and `ext_slow_i`=1 (slow decay), the settled outputs are both sinks on and both sources off, whatever the value of `dir_i`.
- R4: With `drive_en_i`=1 and `chop_off_i`=1, the decay follows `chop_fast_i`: 1 gives the fast pattern of R2 and 0 gives the slow pattern of R3. In this state `ext_slow_i` has no effect on the outputs.
- R5: If `zero_cur_i` is 1 during a decay period, all four outputs are 0 after the next clock edge. They stay 0 even after `zero_cur_i` falls, until a drive period begins. During a drive period, `zero_cur_i` has no effect.
- R6: If `flt_temp_i` or `flt_vreg_i` is 1, all four outputs are 0 after the next clock edge and stay 0 while the fault is present.
- R7: If `flt_cpump_i` is 1, both source outputs are 0 after the next clock edge. Sink outputs continue to follow their commands.
- R8: If `awake_i` is 0 or `flt_vdd_i` is 1, all four outputs are 0 after the next clock edge.
- R9: A switch that turns on does so only after both switches of its leg have been off for `DEAD_CYC` consecutive cycles. A leg whose target changes while it is conducting is off after the next edge. From there its new switch comes on at the (`DEAD_CYC`+1)-th edge after the request changed.
- R10: The source and sink of the same leg are never on together.
- R11: While `rst` is high, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_i | input | 1 | Direction: 1 drives leg A high, 0 drives leg B high |
| drive_en_i | input | 1 | External drive request; 0 starts a decay period |
| ext_slow_i | input | 1 | Decay used when drive_en_i is 0: 1 slow, 0 fast |
| chop_off_i | input | 1 | Internal chopper off period active |
| chop_fast_i | input | 1 | Internal chopper decay state: 1 fast, 0 slow |
| zero_cur_i | input | 1 | Winding current has reached zero |
| awake_i | input | 1 | 0 puts the block to sleep (all off) |
| flt_temp_i | input | 1 | Over-temperature fault |
| flt_vreg_i | input | 1 | Low regulator voltage fault |
| flt_cpump_i | input | 1 | Low charge-pump voltage fault |
| flt_vdd_i | input | 1 | Low logic supply (undervoltage lockout) |
| src_a_o | output | 1 | Leg A source gate command |
| snk_a_o | output | 1 | Leg A sink gate command |
| src_b_o | output | 1 | Leg B source gate command |
| snk_b_o | output | 1 | Leg B sink gate command |

## Verification
The bench sweeps every combination of the five control inputs and compares the settled pattern against an arithmetic model. This catches swapped diagonals and decay routing that reads the external select when it should read the chopper. A reversal of direction is followed edge by edge. A design without dead time, or with a direct source-to-sink swap, shows a switch too early at the `DEAD_CYC`-th edge. The zero-current shutoff is released and then held idle. A design that does not latch it turns the decay pair back on. The bench also checks that the charge-pump fault leaves a sink conducting, which catches a design that treats it as a full shutdown.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    localparam int NUM_LEGS = 2;

    typedef enum logic [1:0] {
        LEG_OFF = 2'b00,
        LEG_SNK = 2'b01,
        LEG_SRC = 2'b10
    } leg_cmd_e;

    typedef enum logic [1:0] {
        MODE_DRIVE = 2'd0,
        MODE_FAST  = 2'd1,
        MODE_SLOW  = 2'd2
    } bridge_mode_e;

    typedef struct packed {
        leg_cmd_e a;
        leg_cmd_e b;
    } bridge_cmd_t;

    localparam bridge_cmd_t ALL_OFF = '{a: LEG_OFF, b: LEG_OFF};

    function automatic bridge_cmd_t mode_pattern(bridge_mode_e mode, logic dir);
        bridge_cmd_t c;
        case (mode)
            MODE_DRIVE: c = dir ? '{a: LEG_SRC, b: LEG_SNK} : '{a: LEG_SNK, b: LEG_SRC};
            MODE_FAST:  c = dir ? '{a: LEG_SNK, b: LEG_SRC} : '{a: LEG_SRC, b: LEG_SNK};
            MODE_SLOW:  c = '{a: LEG_SNK, b: LEG_SNK};
            default:    c = ALL_OFF;
        endcase
        return c;
    endfunction

    function automatic leg_cmd_e drop_source(leg_cmd_e c);
        return (c == LEG_SRC) ? LEG_OFF : c;
    endfunction

endpackage

// File: rtl/hbg_mode_sel.sv
module hbg_mode_sel
    import hbg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        dir_i,
    input  logic        drive_en_i,
    input  logic        ext_slow_i,
    input  logic        chop_off_i,
    input  logic        chop_fast_i,
    input  logic        zero_cur_i,
    output bridge_cmd_t cmd_o
);

    logic         in_decay;
    logic         zc_hold_q;
    logic         zc_kill;
    bridge_mode_e mode;

    assign in_decay = !(drive_en_i && !chop_off_i);

    always_comb begin
        if (!in_decay)
            mode = MODE_DRIVE;
        else if (drive_en_i)
            mode = chop_fast_i ? MODE_FAST : MODE_SLOW;
        else
            mode = ext_slow_i ? MODE_SLOW : MODE_FAST;
    end

    // Zero-current shutoff: held until a drive period starts
    always_ff @(posedge clk) begin
        if (rst)
            zc_hold_q <= 1'b0;
        else
            zc_hold_q <= in_decay && (zc_hold_q || zero_cur_i);
    end

    assign zc_kill = in_decay && (zc_hold_q || zero_cur_i);

    always_comb begin
        if (zc_kill)
            cmd_o = ALL_OFF;
        else
            cmd_o = mode_pattern(mode, dir_i);
    end

    assert_zc_latched_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(in_decay && zero_cur_i) && in_decay) |-> (cmd_o == ALL_OFF));

endmodule

// File: rtl/hbg_protect.sv
module hbg_protect
    import hbg_pkg::*;
(
    input  bridge_cmd_t req_i,
    input  logic        awake_i,
    input  logic        flt_temp_i,
    input  logic        flt_vreg_i,
    input  logic        flt_cpump_i,
    input  logic        flt_vdd_i,
    output bridge_cmd_t cmd_o
);

    logic full_stop;

    assign full_stop = flt_temp_i || flt_vreg_i || flt_vdd_i || !awake_i;

    always_comb begin
        if (full_stop)
            cmd_o = ALL_OFF;
        else if (flt_cpump_i)
            cmd_o = '{a: drop_source(req_i.a), b: drop_source(req_i.b)};
        else
            cmd_o = req_i;
    end

    always_comb begin
        assert_full_stop_R6: assert (!full_stop || cmd_o == ALL_OFF);
    end

endmodule

// File: rtl/hbg_leg_dt.sv
module hbg_leg_dt
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  leg_cmd_e target_i,
    output logic     src_o,
    output logic     snk_o
);

    localparam int CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEAD_CYC - 1);

    leg_cmd_e         state_q;
    logic [CNT_W-1:0] off_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LEG_OFF;
            off_cnt_q <= '0;
        end else if (state_q != LEG_OFF) begin
            if (target_i != state_q) begin
                state_q   <= LEG_OFF;
                off_cnt_q <= '0;
            end
        end else begin
            if (target_i != LEG_OFF && off_cnt_q == CNT_TOP)
                state_q <= target_i;
            else if (off_cnt_q != CNT_TOP)
                off_cnt_q <= off_cnt_q + 1'b1;
        end
    end

    assign src_o = (state_q == LEG_SRC);
    assign snk_o = (state_q == LEG_SNK);

    assert_leg_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(src_o && snk_o));

    assert_turnon_gap_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(src_o) || $rose(snk_o)) |-> $past(!src_o && !snk_o));

endmodule

// File: rtl/hbg_top.sv
module hbg_top
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic dir_i,
    input  logic drive_en_i,
    input  logic ext_slow_i,
    input  logic chop_off_i,
    input  logic chop_fast_i,
    input  logic zero_cur_i,
    input  logic awake_i,
    input  logic flt_temp_i,
    input  logic flt_vreg_i,
    input  logic flt_cpump_i,
    input  logic flt_vdd_i,
    output logic src_a_o,
    output logic snk_a_o,
    output logic src_b_o,
    output logic snk_b_o
);

    bridge_cmd_t req_cmd;
    bridge_cmd_t safe_cmd;
    leg_cmd_e    leg_tgt [NUM_LEGS];
    logic        leg_src [NUM_LEGS];
    logic        leg_snk [NUM_LEGS];

    hbg_mode_sel u_mode (
        .clk         (clk),
        .rst         (rst),
        .dir_i       (dir_i),
        .drive_en_i  (drive_en_i),
        .ext_slow_i  (ext_slow_i),
        .chop_off_i  (chop_off_i),
        .chop_fast_i (chop_fast_i),
        .zero_cur_i  (zero_cur_i),
        .cmd_o       (req_cmd)
    );

    hbg_protect u_prot (
        .req_i       (req_cmd),
        .awake_i     (awake_i),
        .flt_temp_i  (flt_temp_i),
        .flt_vreg_i  (flt_vreg_i),
        .flt_cpump_i (flt_cpump_i),
        .flt_vdd_i   (flt_vdd_i),
        .cmd_o       (safe_cmd)
    );

    assign leg_tgt[0] = safe_cmd.a;
    assign leg_tgt[1] = safe_cmd.b;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbg_leg_dt #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk      (clk),
            .rst      (rst),
            .target_i (leg_tgt[g]),
            .src_o    (leg_src[g]),
            .snk_o    (leg_snk[g])
        );
    end

    assign src_a_o = leg_src[0];
    assign snk_a_o = leg_snk[0];
    assign src_b_o = leg_src[1];
    assign snk_b_o = leg_snk[1];

    assert_stop_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        (flt_temp_i || flt_vreg_i || flt_vdd_i || !awake_i)
        |=> !(src_a_o || snk_a_o || src_b_o || snk_b_o));

    assert_cpump_sources_R7: assert property (@(posedge clk) disable iff (rst)
        flt_cpump_i |=> (!src_a_o && !src_b_o));

    assert_reset_off_R11: assert property (@(posedge clk)
        $past(rst) |-> !(src_a_o || snk_a_o || src_b_o || snk_b_o));

endmodule

// File: tb/hbg_top_bench.sv
module hbg_top_bench;

    localparam int DT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dir_i = 0, drive_en_i = 0, ext_slow_i = 0, chop_off_i = 0, chop_fast_i = 0;
    logic zero_cur_i = 0, awake_i = 1;
    logic flt_temp_i = 0, flt_vreg_i = 0, flt_cpump_i = 0, flt_vdd_i = 0;
    logic src_a_o, snk_a_o, src_b_o, snk_b_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hbg_top #(.DEAD_CYC(DT)) u_hbg_top (.*);

    function automatic logic [3:0] outs();
        return {src_a_o, snk_a_o, src_b_o, snk_b_o};
    endfunction

    // {src_a, snk_a, src_b, snk_b}
    function automatic logic [3:0] model(logic dir, logic en, logic ext, logic co, logic cf);
        logic fast;
        if (en && !co) return dir ? 4'b1001 : 4'b0110;
        fast = en ? cf : !ext;
        if (fast) return dir ? 4'b0110 : 4'b1001;
        return 4'b0101;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic set_ctl(logic d, logic e, logic x, logic co, logic cf);
        dir_i = d; drive_en_i = e; ext_slow_i = x; chop_off_i = co; chop_fast_i = cf;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R11 reset", outs(), 4'b0000);
        rst = 1'b0;

        // R1 R2 R3 R4: sweep of all control combinations
        for (int i = 0; i < 32; i++) begin
            set_ctl(i[0], i[1], i[2], i[3], i[4]);
            tick(DT + 3);
            check(i[1] && !i[3] ? "R1 drive" :
                  (i[1] ? "R4 chopper decay" : (i[2] ? "R3 slow" : "R2 fast")),
                  outs(), model(i[0], i[1], i[2], i[3], i[4]));
        end

        // R9 R10: reversal passes through dead time
        set_ctl(1, 1, 0, 0, 0); tick(DT + 3);
        check("R1 forward", outs(), 4'b1001);
        dir_i = 0;
        tick(1);
        check("R9 off after first edge", outs(), 4'b0000);
        tick(DT - 1);
        check("R9 still off at DEAD edge", outs(), 4'b0000);
        tick(1);
        check("R9 on at DEAD+1 edge", outs(), 4'b0110);

        // R5: zero-current shutoff latch
        set_ctl(1, 0, 0, 0, 0); tick(DT + 3);
        check("R2 fast before zero", outs(), 4'b0110);
        zero_cur_i = 1; tick(1);
        check("R5 zero current off", outs(), 4'b0000);
        zero_cur_i = 0; tick(DT + 3);
        check("R5 latched off", outs(), 4'b0000);
        drive_en_i = 1; tick(DT + 2);
        check("R5 released on drive", outs(), 4'b1001);
        zero_cur_i = 1; tick(DT + 2);
        check("R5 ignored while driving", outs(), 4'b1001);
        zero_cur_i = 0;

        // R6 temp and regulator
        flt_temp_i = 1; tick(1);
        check("R6 temp off", outs(), 4'b0000);
        tick(DT + 2);
        check("R6 temp held", outs(), 4'b0000);
        flt_temp_i = 0; tick(DT + 2);
        check("R6 temp recovered", outs(), 4'b1001);
        flt_vreg_i = 1; tick(1);
        check("R6 vreg off", outs(), 4'b0000);
        flt_vreg_i = 0; tick(DT + 2);

        // R8 sleep and vdd
        awake_i = 0; tick(1);
        check("R8 sleep off", outs(), 4'b0000);
        awake_i = 1; tick(DT + 2);
        check("R8 wake drive", outs(), 4'b1001);
        flt_vdd_i = 1; tick(1);
        check("R8 vdd off", outs(), 4'b0000);
        flt_vdd_i = 0; tick(DT + 2);

        // R7 charge pump
        flt_cpump_i = 1; tick(1);
        check("R7 drive source dropped", outs(), 4'b0001);
        tick(DT + 2);
        check("R7 sink held", outs(), 4'b0001);
        set_ctl(0, 0, 1, 0, 0); tick(DT + 3);
        check("R7 slow sinks kept", outs(), 4'b0101);
        flt_cpump_i = 0; set_ctl(0, 1, 0, 0, 0); tick(DT + 3);
        check("R7 recovered", outs(), 4'b0110);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule